// File: doc/BRIEF.md
# Two-Level Page Translator with Ring Protection

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table held in memory and checks privilege and access rights on every page. A requester presents the address, an access code (read, write or execute) and its current ring. The block then reads the first-level entry and the second-level entry over a simple request/acknowledge memory port. It returns either the translated address or a fault code.

Virtual address bit 31 picks the region. The upper half is a shared region that is used mainly by the operating system and is walked from a global root frame. The lower half belongs to the current address space and is walked from that space's own root frame. Both roots are inputs.

The block handles one translation at a time. Each page entry carries its own two-bit ring field and separate read, write and execute bits. Ring 0 is the most privileged ring. On an access that is allowed, the block maintains the entry's referenced and modified bits. It writes the entry back only when one of those bits actually changes.

Top module: `ring_page_xlate`

## Requirements
- R1: `req_ready_o` is high exactly when the block is idle. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high, and its address, access code and ring are captured on that edge. `req_ready_o` then stays low until the response cycle has passed.
- R2: On success, `rsp_paddr_o[11:0]` equals the virtual address bits 11:0, and `rsp_paddr_o[31:12]` equals the frame field, bits 31:12, of the second-level entry.
- R3: The first read goes to the address `{root, 12'b0} + 4*vaddr[31:22]`. Here root is `shared_root_i` when vaddr bit 31 is 1 and `space_root_i` when it is 0. Both roots are 20-bit frame numbers.
- R4: The second read goes to the address `{l1_frame, 12'b0} + 4*vaddr[21:12]`, where l1_frame is bits 31:12 of the first-level entry. Bits 11:1 of a first-level entry are ignored.
- R5: Present is bit 0 of an entry. A clear present bit at the first level ends the walk after one read. A clear present bit at the second level ends the walk after two reads. In both cases the response carries fault code 1 and no entry is written.
- R6: The access codes are 0 for read, 1 for write, 2 for execute and 3 for reserved. An entry holds its ring in bits 4:3, read permission in bit 5, write permission in bit 6 and execute permission in bit 7. An access is allowed only when the request ring is less than or equal to the entry ring and the matching permission bit is set. Code 3 is never allowed. A denied access returns fault code 2 with no write. An allowed access returns fault code 0.
- R7: An allowed access sets the referenced bit (bit 1). An allowed write also sets the modified bit (bit 2). The block makes exactly one write, of the updated entry, to the second-level entry address, and only when the value changes. Otherwise it makes no write.
- R8: `mem_req_o` stays high with a stable address, write enable and write data until `mem_ack_i` is sampled high. Each access completes on the edge where the acknowledge is sampled.
- R9: `rsp_valid_o` is a single-cycle pulse in the cycle after the edge that acknowledges the walk's last memory access. No memory request is made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 reserved |
| req_ring_i | input | 2 | Current ring of the requester, 0 most privileged |
| shared_root_i | input | 20 | Root table frame for the shared region |
| space_root_i | input | 20 | Root table frame for the current address space |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the table entry |
| mem_wdata_o | output | 32 | Entry value to write |
| mem_ack_i | input | 1 | Memory access complete; read data valid |
| mem_rdata_i | input | 32 | Entry value read |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_paddr_o | output | 32 | Physical address, valid with fault code 0 |
| rsp_fault_o | output | 2 | 0 none, 1 page not present, 2 protection |

## Verification
The response time depends on the walk, not on a fixed latency. Counting from the accepting edge, the response is due n·(L+1) edges later. Here n is the number of table accesses the outcome implies, and L is the number of idle cycles the bench memory waits before each acknowledge. The possible values of n are:
- 1 for a first-level miss,
- 2 for a second-level miss, a protection fault, or an allowed access that changes nothing,
- 3 for an allowed access that needs a writeback.

The bench predicts n from the entry and the request and sweeps L from 0 to 2. It counts falling edges from acceptance until the pulse is seen, and requires the count to equal the prediction exactly. All outputs and the memory model's record of reads and writes are sampled on falling edges, halfway between the edges that change them.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned RING_W = 2;
  localparam int unsigned FLAG_W = 8;

  // entry flag positions
  localparam int unsigned B_PRES    = 0;
  localparam int unsigned B_REF     = 1;
  localparam int unsigned B_MOD     = 2;
  localparam int unsigned B_RING_LO = 3;
  localparam int unsigned B_RD      = 5;
  localparam int unsigned B_WR      = 6;
  localparam int unsigned B_EX      = 7;

  typedef enum logic [1:0] {ACC_RD, ACC_WR, ACC_EX, ACC_BAD} acc_e;
  typedef enum logic [1:0] {FLT_NONE, FLT_PAGE, FLT_PROT, FLT_RSVD} fault_e;
  typedef enum logic [2:0] {S_IDLE, S_L1, S_L2, S_WB, S_DONE} walk_st_e;
endpackage

// File: rtl/xlate_addr.sv
module xlate_addr #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned L1_W  = 10
) (
  input  logic [VA_W-OFF_W-1:0] vpn_i,
  input  logic [VA_W-OFF_W-1:0] shared_root_i,
  input  logic [VA_W-OFF_W-1:0] space_root_i,
  input  logic [VA_W-OFF_W-1:0] l1_frame_i,
  output logic [VA_W-1:0]       l1_addr_o,
  output logic [VA_W-1:0]       l2_addr_o
);
  localparam int unsigned FRAME_W = VA_W - OFF_W;
  localparam int unsigned L2_W    = FRAME_W - L1_W;
  localparam int unsigned LG_B    = $clog2(VA_W / 8);

  logic [L1_W-1:0]    idx1;
  logic [L2_W-1:0]    idx2;
  logic [FRAME_W-1:0] root;

  always_comb begin
    idx1      = vpn_i[FRAME_W-1 -: L1_W];
    idx2      = vpn_i[L2_W-1:0];
    // top address bit selects shared (1) or per-space (0) table
    root      = vpn_i[FRAME_W-1] ? shared_root_i : space_root_i;
    l1_addr_o = {root, {OFF_W{1'b0}}} | (VA_W'(idx1) << LG_B);
    l2_addr_o = {l1_frame_i, {OFF_W{1'b0}}} | (VA_W'(idx2) << LG_B);
  end
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
  import xlate_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  acc_e              acc_i,
  input  logic [RING_W-1:0] ring_i,
  output logic              present_o,
  output logic              allow_o,
  output logic              changed_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic perm;

  always_comb begin
    case (acc_i)
      ACC_RD:  perm = flags_i[B_RD];
      ACC_WR:  perm = flags_i[B_WR];
      ACC_EX:  perm = flags_i[B_EX];
      default: perm = 1'b0;
    endcase
    present_o = flags_i[B_PRES];
    // lower ring number = more privilege
    allow_o   = present_o && perm && (ring_i <= flags_i[B_RING_LO +: RING_W]);
    flags_o   = flags_i;
    flags_o[B_REF] = 1'b1;
    if (acc_i == ACC_WR) flags_o[B_MOD] = 1'b1;
    changed_o = (flags_o != flags_i);
  end
endmodule

// File: rtl/ring_page_xlate.sv
module ring_page_xlate
  import xlate_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned L1_W  = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [VA_W-1:0]       req_vaddr_i,
  input  logic [1:0]            req_acc_i,
  input  logic [RING_W-1:0]     req_ring_i,
  input  logic [VA_W-OFF_W-1:0] shared_root_i,
  input  logic [VA_W-OFF_W-1:0] space_root_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [VA_W-1:0]       mem_addr_o,
  output logic [VA_W-1:0]       mem_wdata_o,
  input  logic                  mem_ack_i,
  input  logic [VA_W-1:0]       mem_rdata_i,
  output logic                  rsp_valid_o,
  output logic [VA_W-1:0]       rsp_paddr_o,
  output logic [1:0]            rsp_fault_o
);
  localparam int unsigned FRAME_W = VA_W - OFF_W;

  walk_st_e            state_q, state_d;
  logic [VA_W-1:0]     vaddr_q, pte_q, paddr_q;
  logic [FRAME_W-1:0]  l1_frame_q;
  acc_e                acc_q;
  logic [RING_W-1:0]   ring_q;
  fault_e              fault_q;

  logic [VA_W-1:0]     l1_addr, l2_addr;
  logic [FLAG_W-1:0]   flags_new;
  logic                pte_pres, pte_allow, pte_chg;
  logic                accept;

  xlate_addr #(.VA_W(VA_W), .OFF_W(OFF_W), .L1_W(L1_W)) u_addr (
    .vpn_i         (vaddr_q[VA_W-1:OFF_W]),
    .shared_root_i (shared_root_i),
    .space_root_i  (space_root_i),
    .l1_frame_i    (l1_frame_q),
    .l1_addr_o     (l1_addr),
    .l2_addr_o     (l2_addr)
  );

  // judged straight off the read data in the ack cycle
  xlate_perm u_perm (
    .flags_i   (mem_rdata_i[FLAG_W-1:0]),
    .acc_i     (acc_q),
    .ring_i    (ring_q),
    .present_o (pte_pres),
    .allow_o   (pte_allow),
    .changed_o (pte_chg),
    .flags_o   (flags_new)
  );

  assign accept = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: if (accept) state_d = S_L1;
      S_L1:   if (mem_ack_i) state_d = mem_rdata_i[B_PRES] ? S_L2 : S_DONE;
      S_L2:   if (mem_ack_i) state_d = (pte_allow && pte_chg) ? S_WB : S_DONE;
      S_WB:   if (mem_ack_i) state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      vaddr_q    <= '0;
      acc_q      <= ACC_RD;
      ring_q     <= '0;
      fault_q    <= FLT_NONE;
      l1_frame_q <= '0;
      pte_q      <= '0;
      paddr_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vaddr_q <= req_vaddr_i;
        acc_q   <= acc_e'(req_acc_i);
        ring_q  <= req_ring_i;
        fault_q <= FLT_NONE;
      end
      if (state_q == S_L1 && mem_ack_i) begin
        l1_frame_q <= mem_rdata_i[VA_W-1:OFF_W];
        if (!mem_rdata_i[B_PRES]) fault_q <= FLT_PAGE;
      end
      if (state_q == S_L2 && mem_ack_i) begin
        if (!pte_pres) begin
          fault_q <= FLT_PAGE;
        end else if (!pte_allow) begin
          fault_q <= FLT_PROT;
        end else begin
          pte_q   <= {mem_rdata_i[VA_W-1:FLAG_W], flags_new};
          paddr_q <= {mem_rdata_i[VA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
        end
      end
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_L1) || (state_q == S_L2) || (state_q == S_WB);
  assign mem_we_o    = (state_q == S_WB);
  assign mem_addr_o  = (state_q == S_L1) ? l1_addr : l2_addr;
  assign mem_wdata_o = pte_q;
  assign rsp_valid_o = (state_q == S_DONE);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;

  p_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_NONE) |-> rsp_paddr_o[OFF_W-1:0] == vaddr_q[OFF_W-1:0]);

  p_region_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && state_q == S_L1) |->
      mem_addr_o[VA_W-1:OFF_W] == (vaddr_q[VA_W-1] ? shared_root_i : space_root_i));

  p_ring_ok_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_NONE) |->
      (ring_q <= pte_q[B_RING_LO +: RING_W]) && pte_q[B_REF] && pte_q[B_PRES]);

  p_wb_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[B_REF] && mem_wdata_o[B_PRES]);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_quiet_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_o && rsp_fault_o != FLT_RSVD);
endmodule

// File: tb/ring_page_xlate_bench.sv
module ring_page_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc, req_ring;
  logic [19:0] shared_root, space_root;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int total = 0;
  int bad   = 0;
  int lat   = 0;
  int wcnt  = 0;
  int rcnt  = 0;
  int cnt   = 0;
  logic [31:0] rd_addr [2];
  logic [31:0] mem [logic [31:0]];

  ring_page_xlate u_ring_page_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_acc_i(req_acc), .req_ring_i(req_ring),
    .shared_root_i(shared_root), .space_root_i(space_root),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: acknowledges after lat idle cycles
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        if (cnt == lat) begin
          cnt = 0;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            wcnt++;
          end else begin
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            if (rcnt < 2) rd_addr[rcnt] = mem_addr;
            rcnt++;
          end
          mem_ack = 1'b1;
          @(posedge clk);
          #1 mem_ack = 1'b0;
        end else begin
          cnt++;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic do_xlate(input logic [31:0] va, input logic [1:0] ac, input logic [1:0] rg,
                          output logic [1:0] f, output logic [31:0] pa, output int cyc,
                          output bit rdy_bad, output bit pulse_bad);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_acc   = ac;
    req_ring  = rg;
    @(posedge clk);
    #1;
    // scramble inputs after acceptance (R1 capture)
    req_valid = 1'b0;
    req_vaddr = ~va;
    req_acc   = ~ac;
    req_ring  = ~rg;
    cyc     = 0;
    rdy_bad = 1'b0;
    forever begin
      @(negedge clk);
      if (req_ready) rdy_bad = 1'b1;
      if (rsp_valid) break;
      cyc++;
    end
    f  = rsp_fault;
    pa = rsp_paddr;
    @(negedge clk);
    pulse_bad = rsp_valid;
  endtask

  initial begin
    int t;
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    req_vaddr   = '0;
    req_acc     = '0;
    req_ring    = '0;
    shared_root = 20'h00020;
    space_root  = 20'h00010;
    t = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R9 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R8 reset mem_req", {31'b0, mem_req}, 32'd0);
    rst_n = 1'b1;

    // sweep: ring x access x page ring x perm bits x prior ref/mod
    for (int rg = 0; rg < 4; rg++)
      for (int ac = 0; ac < 4; ac++)
        for (int pr = 0; pr < 4; pr++)
          for (int pm = 0; pm < 8; pm++)
            for (int rm = 0; rm < 4; rm++) begin
              logic [31:0] va, l1a, l2a, pte, exp_pte, pa;
              logic [19:0] rootf, l2f, df;
              logic [1:0]  f;
              bit          ok, rdy_bad, pulse_bad;
              int          nacc, cyc;
              lat   = t % 3;
              va    = {t[0], 9'(t * 7), 10'(t * 13), 12'(t * 37)};
              rootf = va[31] ? shared_root : space_root;
              l2f   = 20'h00300 + 20'(t & 255);
              df    = 20'hA0000 ^ 20'(t);
              l1a   = {rootf, 12'h0} + {20'h0, va[31:22], 2'b00};
              l2a   = {l2f, 12'h0} + {20'h0, va[21:12], 2'b00};
              pte   = {df, 4'h0, 3'(pm), 2'(pr), 2'(rm), 1'b1};
              mem.delete();
              mem[l1a] = {l2f, 12'hAA1};
              mem[l2a] = pte;
              ok = (ac != 3) && (rg <= pr) && (((pm >> ac) & 1) == 1);
              exp_pte = pte;
              if (ok) begin
                exp_pte[1] = 1'b1;
                if (ac == 1) exp_pte[2] = 1'b1;
              end
              nacc = (ok && exp_pte != pte) ? 3 : 2;
              wcnt = 0;
              rcnt = 0;
              do_xlate(va, 2'(ac), 2'(rg), f, pa, cyc, rdy_bad, pulse_bad);
              chk("R6 fault code", {30'b0, f}, ok ? 32'd0 : 32'd2);
              if (ok) chk("R2 physical address", pa, {df, va[11:0]});
              chk("R8 R9 response cycle", cyc, nacc * (lat + 1));
              chk("R7 write count", wcnt, nacc - 2);
              chk("R7 entry after walk", mem[l2a], exp_pte);
              chk("R3 first-level address", rd_addr[0], l1a);
              chk("R4 second-level address", rd_addr[1], l2a);
              chk("R1 ready low while busy", {31'b0, rdy_bad}, 32'd0);
              chk("R9 single-cycle pulse", {31'b0, pulse_bad}, 32'd0);
              t++;
            end

    // not-present at first level (k<6) and second level (k>=6)
    for (int k = 0; k < 12; k++) begin
      logic [31:0] va, l1a, l2a, pte, pa;
      logic [19:0] rootf, l2f;
      logic [1:0]  f;
      bit          rdy_bad, pulse_bad;
      int          cyc, nrd;
      lat   = k % 3;
      va    = {k[0], 9'(k * 11), 10'(k * 5), 12'(k * 91)};
      rootf = va[31] ? shared_root : space_root;
      l2f   = 20'h00400 + 20'(k);
      l1a   = {rootf, 12'h0} + {20'h0, va[31:22], 2'b00};
      l2a   = {l2f, 12'h0} + {20'h0, va[21:12], 2'b00};
      mem.delete();
      if (k < 6) begin
        mem[l1a] = {l2f, 12'h0AA};
        pte      = {20'hBEEF0, 12'hFF9};
        nrd      = 1;
      end else begin
        mem[l1a] = {l2f, 12'h001};
        pte      = {20'hBEEF0, 12'hFF8};
        nrd      = 2;
      end
      mem[l2a] = pte;
      wcnt = 0;
      rcnt = 0;
      do_xlate(va, 2'd1, 2'd0, f, pa, cyc, rdy_bad, pulse_bad);
      chk("R5 page fault code", {30'b0, f}, 32'd1);
      chk("R5 reads made", rcnt, nrd);
      chk("R5 no write", wcnt, 0);
      chk("R5 entry untouched", mem[l2a], pte);
      chk("R8 R9 response cycle on miss", cyc, nrd * (lat + 1));
      chk("R9 single-cycle pulse on miss", {31'b0, pulse_bad}, 32'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule